// File: doc/BRIEF.md
# Lockable RNG Control Register

This block is the control register of a random number generator, written from a simple register bus. It holds the generator enable, the interrupt enable, a clock-error-detection control, a clock divider, a compliance-mode select and three opaque tuning fields. Every write must be armed by a magic word written in the bus write just before it. Tuning and divider fields change only when the same write also requests a conditioning soft reset. A sticky lock bit freezes those fields until the block is reset.

The soft-reset bit drives a request into the slower RNG clock domain. Software writes 1 to hold the conditioning logic, the FIFOs and the status in reset, then writes 0 to release it. The RNG side answers on `cond_rst_done`. It raises the signal while it sees the request and drops it once the request is withdrawn. The soft-reset bit keeps reading 1 until that answer has travelled back, so software can poll for completion.

Top module: `rng_ctl_reg`

## Requirements
- R1: After reset the register reads 0x0080_0000 and `cond_rst_req` is low.
- R2: A non-magic write that does not directly follow a magic-word write (0x17590ABC) leaves the register unchanged.
- R3: A magic-word write does not alter the register. Any other write, applied or not, clears the arming, so a second write after one magic word is discarded. A repeated magic word re-arms.
- R4: An armed write updates the interrupt enable (bit 3) and the generator enable (bit 2) whatever the other bits hold.
- R5: An armed write changes bits 29:4 only when its bit 30 is 1. Those bits are the tuning field 1 (25:20), the clock divider (19:16), tuning field 2 (15:13), the compliance select (12), tuning field 3 (11:8) and the clock-error-detect control (5).
- R6: An armed write with bit 31 = 1 sets the lock. No write can clear it; only the block reset does.
- R7: While the lock is set, bits 29:4 ignore every write, even one with bit 30 = 1.
- R8: Bits 29:26, 7:6, 4 and 1:0 always read 0.
- R9: Bit 30 reads 1 from an armed write of 1 until the soft reset has finished. After the releasing write of 0 it stays 1 until the RNG side has dropped `cond_rst_done`. `cond_rst_req` is high while the reset is held.
- R10: The soft-reset sequence changes no register bit other than bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rng_clk | input | 1 | RNG-domain clock |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value |
| rng_en | output | 1 | Generator enable |
| irq_en | output | 1 | Interrupt enable |
| ced_ctl | output | 1 | Clock-error-detect control |
| nist_sel | output | 1 | Compliance-mode select |
| clk_div | output | 4 | RNG clock divider |
| cfg1 | output | 6 | Tuning field 1 |
| cfg2 | output | 3 | Tuning field 2 |
| cfg3 | output | 4 | Tuning field 3 |
| cond_rst_req | output | 1 | Soft-reset request, RNG domain |
| cond_rst_done | input | 1 | Soft-reset answer from the RNG domain |

## Verification
The write rules are tried with five kinds of write:
- Writes with no magic word in front.
- Magic-only writes.
- Armed writes with bit 30 clear, which may touch only bits 3:2.
- Armed all-ones and all-zero configuration writes, which expose reserved bits and full field coverage.
- Writes while locked.

Each kind separates one acceptance condition from the others. A second write after a single magic word, and a double magic word, show whether arming is cleared or refreshed. The soft-reset sequence is checked for the readback of bit 30 during hold and release, for its clearing only after the RNG side has answered, and for the other fields staying intact throughout.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LOCK_POS = 31;
  localparam int unsigned CRST_POS = 30;

  // field positions
  localparam int unsigned CFG1_LO = 20;
  localparam int unsigned CFG1_W  = 6;
  localparam int unsigned DIV_LO  = 16;
  localparam int unsigned DIV_W   = 4;
  localparam int unsigned CFG2_LO = 13;
  localparam int unsigned CFG2_W  = 3;
  localparam int unsigned NIST_POS = 12;
  localparam int unsigned CFG3_LO = 8;
  localparam int unsigned CFG3_W  = 4;
  localparam int unsigned CED_POS = 5;
  localparam int unsigned IRQ_POS = 3;
  localparam int unsigned EN_POS  = 2;

  // groups of bits with a common write rule
  localparam logic [WORD_W-1:0] CFG_MASK  = 32'h03FF_FF20;
  localparam logic [WORD_W-1:0] FREE_MASK = 32'h0000_000C;
  localparam logic [WORD_W-1:0] RSV_MASK  = 32'h3C00_00D3;
  localparam logic [WORD_W-1:0] LOCK_MASK = 32'h8000_0000;
  localparam logic [WORD_W-1:0] CRST_MASK = 32'h4000_0000;

endpackage

// File: rtl/rng_ctl_rst_sync.sv
module rng_ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rng_ctl_sync.sv
module rng_ctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[STAGES-2:0], d};
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/rng_ctl_regfile.sv
module rng_ctl_regfile
  import rng_ctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] MAGIC     = 32'h1759_0ABC,
  parameter logic [WORD_W-1:0] RESET_VAL = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctl_o,
  output logic              armed_o,
  output logic              acc_o
);

  localparam logic [WORD_W-1:0] KEEP_MASK = ~(RSV_MASK | CRST_MASK);

  logic [WORD_W-1:0] ctl_q, ctl_d;
  logic              armed_q, armed_d;
  logic              is_magic, acc, cfg_ok;

  // next state
  always_comb begin
    is_magic = wr_en && (wr_data == MAGIC);
    acc      = wr_en && armed_q && !is_magic;
    cfg_ok   = wr_data[CRST_POS] && !ctl_q[LOCK_POS];

    armed_d = is_magic;

    ctl_d = (ctl_q & ~FREE_MASK) | (wr_data & FREE_MASK);
    if (cfg_ok) begin
      ctl_d = (ctl_d & ~CFG_MASK) | (wr_data & CFG_MASK);
    end
    ctl_d[LOCK_POS] = ctl_q[LOCK_POS] | wr_data[LOCK_POS];
    ctl_d = ctl_d & KEEP_MASK;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= RESET_VAL & KEEP_MASK;
      armed_q <= 1'b0;
    end else begin
      if (acc) begin
        ctl_q <= ctl_d;
      end
      if (wr_en) begin
        armed_q <= armed_d;
      end
    end
  end

  assign ctl_o   = ctl_q;
  assign armed_o = armed_q;
  assign acc_o   = acc;

endmodule

// File: rtl/rng_ctl_softrst.sv
module rng_ctl_softrst #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rng_clk,
  input  logic rng_rst_n,
  input  logic acc,
  input  logic wr_crst,
  input  logic done_rng,
  output logic busy,
  output logic req_rng,
  output logic done_bus
);

  logic hold_q, hold_d;
  logic pend_q, pend_d;
  logic seen_q, seen_d;
  logic req_q, req_d;
  logic done_s;
  logic finish;

  // next state
  always_comb begin
    hold_d = acc ? wr_crst : hold_q;
    finish = pend_q && !hold_q && seen_q && !done_s;

    pend_d = pend_q;
    if (acc && !wr_crst && hold_q) begin
      pend_d = 1'b1;
    end else if (finish) begin
      pend_d = 1'b0;
    end

    seen_d = seen_q;
    if (finish) begin
      seen_d = 1'b0;
    end else if (done_s) begin
      seen_d = 1'b1;
    end

    req_d = hold_d | (pend_d & ~seen_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pend_q <= pend_d;
      seen_q <= seen_d;
      req_q  <= req_d;
    end
  end

  rng_ctl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (rng_clk),
    .rst_n (rng_rst_n),
    .d     (req_q),
    .q     (req_rng)
  );

  rng_ctl_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (done_rng),
    .q     (done_s)
  );

  assign busy     = hold_q | pend_q;
  assign done_bus = done_s;

endmodule

// File: rtl/rng_ctl_reg.sv
module rng_ctl_reg
  import rng_ctl_pkg::*;
#(
  parameter logic [31:0] MAGIC       = 32'h1759_0ABC,
  parameter logic [31:0] RESET_VAL   = 32'h0080_0000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rng_clk,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        rng_en,
  output logic        irq_en,
  output logic        ced_ctl,
  output logic        nist_sel,
  output logic [3:0]  clk_div,
  output logic [5:0]  cfg1,
  output logic [2:0]  cfg2,
  output logic [3:0]  cfg3,
  output logic        cond_rst_req,
  input  logic        cond_rst_done
);

  logic        bus_rst_n;
  logic        rng_rst_n;
  logic [31:0] ctl;
  logic        armed;
  logic        acc;
  logic        busy;
  logic        done_bus;

  rng_ctl_rst_sync #(.STAGES(SYNC_STAGES)) u_bus_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (bus_rst_n)
  );

  rng_ctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rng_rst (
    .clk     (rng_clk),
    .arst_n  (rst_n),
    .rst_n_o (rng_rst_n)
  );

  rng_ctl_regfile #(.MAGIC(MAGIC), .RESET_VAL(RESET_VAL)) u_regs (
    .clk     (clk),
    .rst_n   (bus_rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctl_o   (ctl),
    .armed_o (armed),
    .acc_o   (acc)
  );

  rng_ctl_softrst #(.SYNC_STAGES(SYNC_STAGES)) u_softrst (
    .clk       (clk),
    .rst_n     (bus_rst_n),
    .rng_clk   (rng_clk),
    .rng_rst_n (rng_rst_n),
    .acc       (acc),
    .wr_crst   (wr_data[CRST_POS]),
    .done_rng  (cond_rst_done),
    .busy      (busy),
    .req_rng   (cond_rst_req),
    .done_bus  (done_bus)
  );

  always_comb begin
    rd_data           = ctl;
    rd_data[CRST_POS] = busy;
  end

  assign rng_en   = ctl[EN_POS];
  assign irq_en   = ctl[IRQ_POS];
  assign ced_ctl  = ctl[CED_POS];
  assign nist_sel = ctl[NIST_POS];
  assign clk_div  = ctl[DIV_LO  +: DIV_W];
  assign cfg1     = ctl[CFG1_LO +: CFG1_W];
  assign cfg2     = ctl[CFG2_LO +: CFG2_W];
  assign cfg3     = ctl[CFG3_LO +: CFG3_W];

endmodule

// File: rtl/rng_ctl_reg_chk.sv
module rng_ctl_reg_chk
  import rng_ctl_pkg::*;
#(
  parameter logic [31:0] MAGIC = 32'h1759_0ABC
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        armed,
  input logic        done_s
);

  p_unarmed_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed) |=> ($stable(rd_data[31]) && $stable(rd_data[29:0])));

  p_magic_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == MAGIC) |=> ($stable(rd_data[31]) && $stable(rd_data[29:0])));

  p_free_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && armed && wr_data != MAGIC) |=> (rd_data[3:2] == $past(wr_data[3:2])));

  p_cfg_needs_crst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CRST_POS]) |=> $stable(rd_data[29:4]));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LOCK_POS] |=> rd_data[LOCK_POS]);

  p_locked_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LOCK_POS] |=> $stable(rd_data[29:4]));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & RSV_MASK) == '0));

  p_busy_ends_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[CRST_POS]) |-> !done_s);

endmodule

bind rng_ctl_reg rng_ctl_reg_chk #(.MAGIC(MAGIC)) u_chk (
  .clk     (clk),
  .rst_n   (bus_rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .armed   (armed),
  .done_s  (done_bus)
);

// File: tb/rng_ctl_reg_test.sv
module rng_ctl_reg_test;

  localparam logic [31:0] MAGIC = 32'h1759_0ABC;
  localparam logic [31:0] NO30  = 32'hBFFF_FFFF;

  typedef struct packed {
    logic        pre;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_000C, 32'h0080_0000, 4'd2},  // R2 not armed
    '{1'b1, 32'h0000_000C, 32'h0080_000C, 4'd4},  // R4 enables only
    '{1'b1, 32'h0010_0004, 32'h0080_0004, 4'd5},  // R5 cfg without bit 30
    '{1'b1, 32'h4155_A728, 32'h0155_A728, 4'd5},  // R5 cfg with bit 30
    '{1'b1, 32'h7FFF_FFFF, 32'h03FF_FF2C, 4'd8},  // R8 reserved stay 0
    '{1'b1, 32'h4000_0000, 32'h0000_0000, 4'd5},  // R5 clear all
    '{1'b1, 32'hC080_0004, 32'h8080_0004, 4'd6},  // R6 set lock
    '{1'b1, 32'h4300_0008, 32'h8080_0008, 4'd7},  // R7 locked cfg
    '{1'b1, 32'h0000_0000, 32'h8080_0000, 4'd6}   // R6 lock not cleared
  };

  logic        clk = 1'b0;
  logic        rng_clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rng_en, irq_en, ced_ctl, nist_sel;
  logic [3:0]  clk_div;
  logic [5:0]  cfg1;
  logic [2:0]  cfg2;
  logic [3:0]  cfg3;
  logic        cond_rst_req;
  logic        cond_rst_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always #6.5 rng_clk = ~rng_clk;

  // RNG-side responder model: answers the request one RNG clock later
  always @(posedge rng_clk or negedge rst_n) begin
    if (!rst_n) cond_rst_done <= 1'b0;
    else        cond_rst_done <= cond_rst_req;
  end

  rng_ctl_reg uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rng_clk       (rng_clk),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .rng_en        (rng_en),
    .irq_en        (irq_en),
    .ced_ctl       (ced_ctl),
    .nist_sel      (nist_sel),
    .clk_div       (clk_div),
    .cfg1          (cfg1),
    .cfg2          (cfg2),
    .cfg3          (cfg3),
    .cond_rst_req  (cond_rst_req),
    .cond_rst_done (cond_rst_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic do_reset();
    wr_en   = 1'b0;
    wr_data = '0;
    rst_n   = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // finish a held soft reset and wait for bit 30 to clear
  task automatic release_crst(input string tag);
    if (rd_data[30]) begin
      repeat (30) @(negedge clk);
      wr(MAGIC);
      wr(rd_data & NO30);
      for (int i = 0; i < 200 && rd_data[30]; i++) @(negedge clk);
      chk(tag, {31'd0, rd_data[30]}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 reset value", rd_data, 32'h0080_0000);
    chk("R1 request idle", {31'd0, cond_rst_req}, 32'd0);
    chk("R1 fields", {clk_div, cfg1, cfg2, cfg3, rng_en, irq_en, ced_ctl, nist_sel},
        {4'h0, 6'h08, 3'h0, 4'h0, 4'h0});

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].pre) wr(MAGIC);
      wr(VECS[v].data);
      chk($sformatf("R%0d vector %0d", VECS[v].req, v), rd_data & NO30, VECS[v].exp);
      release_crst("R9 vector cleanup");
    end
    chk("R4 irq_en/rng_en pins", {30'd0, irq_en, rng_en}, 32'd0);

    // R3 arming rules, after reset clears the lock
    do_reset();
    chk("R6 lock cleared by reset", rd_data, 32'h0080_0000);
    wr(MAGIC);
    chk("R3 magic alone", rd_data, 32'h0080_0000);
    wr(32'h0000_000C);
    chk("R3 armed write applied", rd_data, 32'h0080_000C);
    wr(32'h0000_0004);
    chk("R3 second write discarded", rd_data, 32'h0080_000C);
    wr(MAGIC);
    wr(MAGIC);
    wr(32'h0000_0008);
    chk("R3 re-armed by repeated magic", rd_data, 32'h0080_0008);

    // R9 / R10 soft-reset sequence
    wr(MAGIC);
    wr(32'h4080_0008);
    chk("R9 bit30 set on hold", rd_data, 32'h4080_0008);
    repeat (30) @(negedge clk);
    chk("R9 request reaches RNG side", {31'd0, cond_rst_req}, 32'd1);
    chk("R10 hold keeps fields", rd_data, 32'h4080_0008);
    wr(MAGIC);
    wr(32'h0080_0008);
    chk("R9 bit30 still set after release", rd_data, 32'h4080_0008);
    @(negedge clk);
    chk("R9 bit30 set one cycle later", {31'd0, rd_data[30]}, 32'd1);
    for (int i = 0; i < 200 && rd_data[30]; i++) @(negedge clk);
    chk("R9 bit30 clears", {31'd0, rd_data[30]}, 32'd0);
    chk("R9 answer dropped before clear", {31'd0, cond_rst_done}, 32'd0);
    chk("R10 fields after soft reset", rd_data, 32'h0080_0008);
    repeat (20) @(negedge clk);
    chk("R9 request idle after completion", {31'd0, cond_rst_req}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule